// File: doc/BRIEF.md
# Boot ROM Relocation Pager

This block manages where an expansion card's 32 KB ROM appears in a 20-bit host address space during start-up. The card also supplies RAM in the expansion-ROM window at $C0000. Out of reset the ROM is decoded only in a low window at $10000–$17FFF. There it does not disturb the host's contiguous RAM sizing.

The host start-up scan cannot find the ROM at that low address, so the pager adds a temporary second image. A read of the cartridge-slot probe address $0C000 turns on a mirror of the ROM at $C0000–$C7FFF, where the host scan looks next. While the mirror is on, ROM reads in that window override the card RAM. The first read of $10000 after that shows that the mirrored code has jumped to the primary copy. This read retires the mirror, and the window becomes RAM again until the next reset.

All state changes take effect when the address strobe of the triggering read is released. The bus cycle that caused a change always completes with the mapping that was in force when it started.

Top module: `rom_hop_pager`

## Requirements
- R1: After reset the pager is in the boot mapping. A read of $C0000–$C7FFF asserts `ram_cs` and leaves `rom_cs` low.
- R2: A read anywhere in $10000–$17FFF asserts `rom_cs` in every state. An access outside both windows asserts neither select.
- R3: A read of exactly $0C000 in the boot mapping switches on the mirror. The switch takes effect only after `bus_as_n` returns high, so the rest of that strobe keeps the old mapping.
- R4: With the mirror on, a read in $C0000–$C7FFF asserts `rom_cs` and not `ram_cs`. A write there asserts `ram_cs` and not `rom_cs`.
- R5: With the mirror on, a read of exactly $10000 retires the mirror once its strobe ends. From then on, reads in $C0000–$C7FFF select RAM.
- R6: A read of $10000 while still in the boot mapping does not change the mapping.
- R7: A write to $0C000 or to $10000 never changes the mapping.
- R8: `rom_cs` is never asserted for a write, in either window.
- R9: The final mapping persists through further probe reads and ends only on reset. Reset returns the block to the boot mapping.
- R10: While `bus_as_n` is high, both selects are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 20 | Host address bus |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| rom_cs | output | 1 | ROM chip select, active high |
| ram_cs | output | 1 | Card RAM select for the $C0000 window, active high |

## Verification
Two functions can act within a single strobe: the decode of the current access and the state change that the same access triggers. To provoke this, the bench keeps the strobe low after a trigger read and moves the address into the $C0000 window before releasing it. Both for the probe and for the retiring read, the select seen within that strobe must still reflect the previous mapping. The next strobe must show the new mapping.

// File: rtl/rom_hop_pkg.sv
package rom_hop_pkg;

    typedef enum logic [1:0] {
        PG_BOOT   = 2'd0,
        PG_MIRROR = 2'd1,
        PG_FINAL  = 2'd2
    } pg_state_e;

    typedef struct packed {
        pg_state_e state;
        logic      strb_seen;
        logic      probe_seen;
        logic      exec_seen;
    } pg_seq_t;

endpackage

// File: rtl/pg_win_match.sv
module pg_win_match #(
    parameter int               AW      = 20,
    parameter int               SPAN_AW = 15,
    parameter logic [AW-1:0]    BASE    = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW-1:0] SPAN_MASK = (AW)'((64'd1 << SPAN_AW) - 64'd1);
    localparam logic [AW-1:0] TAG_MASK  = ~SPAN_MASK;

    always_comb begin
        hit = (((addr ^ BASE) & TAG_MASK) == '0);
    end
endmodule

// File: rtl/pg_addr_dec.sv
module pg_addr_dec #(
    parameter int            AW         = 20,
    parameter int            ROM_AW     = 15,
    parameter logic [AW-1:0] PRIM_BASE  = 20'h10000,
    parameter logic [AW-1:0] MIR_BASE   = 20'hC0000,
    parameter logic [AW-1:0] PROBE_ADDR = 20'h0C000,
    parameter logic [AW-1:0] EXEC_ADDR  = 20'h10000
) (
    input  logic [AW-1:0] addr,
    output logic          prim_hit,
    output logic          mir_hit,
    output logic          probe_hit,
    output logic          exec_hit
);
    localparam int NWIN = 2;
    logic [NWIN-1:0] win_hit;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        pg_win_match #(
            .AW     (AW),
            .SPAN_AW(ROM_AW),
            .BASE   ((g == 0) ? PRIM_BASE : MIR_BASE)
        ) u_match (
            .addr(addr),
            .hit (win_hit[g])
        );
    end

    always_comb begin
        prim_hit  = win_hit[0];
        mir_hit   = win_hit[1];
        probe_hit = (addr == PROBE_ADDR);
        exec_hit  = (addr == EXEC_ADDR);
    end
endmodule

// File: rtl/pg_seq.sv
module pg_seq
    import rom_hop_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_as_n,
    input  logic      probe_rd,
    input  logic      exec_rd,
    output pg_state_e state_q
);
    pg_seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!bus_as_n) begin
            // strobe active: note what this cycle touched, mapping held
            r_d.strb_seen = 1'b1;
            if (probe_rd) r_d.probe_seen = 1'b1;
            if (exec_rd)  r_d.exec_seen  = 1'b1;
        end else if (r_q.strb_seen) begin
            // strobe just released: apply the pending change
            unique case (r_q.state)
                PG_BOOT:   if (r_q.probe_seen) r_d.state = PG_MIRROR;
                PG_MIRROR: if (r_q.exec_seen)  r_d.state = PG_FINAL;
                default:   r_d.state = r_q.state;
            endcase
            r_d.strb_seen  = 1'b0;
            r_d.probe_seen = 1'b0;
            r_d.exec_seen  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: PG_BOOT, strb_seen: 1'b0, probe_seen: 1'b0, exec_seen: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q = r_q.state;
endmodule

// File: rtl/pg_select.sv
module pg_select
    import rom_hop_pkg::*;
(
    input  logic      bus_as_n,
    input  logic      bus_rd,
    input  logic      prim_hit,
    input  logic      mir_hit,
    input  pg_state_e state,
    output logic      rom_cs,
    output logic      ram_cs
);
    logic act, mirror_on;

    always_comb begin
        act       = !bus_as_n;
        mirror_on = (state == PG_MIRROR);
        rom_cs    = act && bus_rd && (prim_hit || (mir_hit && mirror_on));
        ram_cs    = act && mir_hit && (!mirror_on || !bus_rd);
    end
endmodule

// File: rtl/rom_hop_pager.sv
module rom_hop_pager
    import rom_hop_pkg::*;
#(
    parameter int            AW         = 20,
    parameter int            ROM_AW     = 15,
    parameter logic [AW-1:0] PRIM_BASE  = 20'h10000,
    parameter logic [AW-1:0] MIR_BASE   = 20'hC0000,
    parameter logic [AW-1:0] PROBE_ADDR = 20'h0C000,
    parameter logic [AW-1:0] EXEC_ADDR  = 20'h10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_as_n,
    input  logic          bus_rd,
    output logic          rom_cs,
    output logic          ram_cs
);
    logic      prim_hit, mir_hit, probe_hit, exec_hit;
    logic      probe_rd, exec_rd;
    pg_state_e state_q;

    pg_addr_dec #(
        .AW        (AW),
        .ROM_AW    (ROM_AW),
        .PRIM_BASE (PRIM_BASE),
        .MIR_BASE  (MIR_BASE),
        .PROBE_ADDR(PROBE_ADDR),
        .EXEC_ADDR (EXEC_ADDR)
    ) u_dec (
        .addr     (bus_addr),
        .prim_hit (prim_hit),
        .mir_hit  (mir_hit),
        .probe_hit(probe_hit),
        .exec_hit (exec_hit)
    );

    always_comb begin
        probe_rd = probe_hit && bus_rd;
        exec_rd  = exec_hit && bus_rd;
    end

    pg_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_as_n(bus_as_n),
        .probe_rd(probe_rd),
        .exec_rd (exec_rd),
        .state_q (state_q)
    );

    pg_select u_sel (
        .bus_as_n(bus_as_n),
        .bus_rd  (bus_rd),
        .prim_hit(prim_hit),
        .mir_hit (mir_hit),
        .state   (state_q),
        .rom_cs  (rom_cs),
        .ram_cs  (ram_cs)
    );
endmodule

// File: rtl/rom_hop_pager_chk.sv
module rom_hop_pager_chk
    import rom_hop_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      bus_as_n,
    input logic      bus_rd,
    input logic      prim_hit,
    input logic      rom_cs,
    input logic      ram_cs,
    input pg_state_e state_q
);
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_as_n |-> (!rom_cs && !ram_cs));

    // R8
    no_rom_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> !rom_cs);

    // R2
    prim_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && bus_rd && prim_hit) |-> rom_cs);

    // R4
    sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs));

    // R3
    hold_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && $past(!bus_as_n)) |-> $stable(state_q));

    // R9
    final_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PG_FINAL) |=> (state_q == PG_FINAL));
endmodule

bind rom_hop_pager rom_hop_pager_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_as_n(bus_as_n),
    .bus_rd  (bus_rd),
    .prim_hit(prim_hit),
    .rom_cs  (rom_cs),
    .ram_cs  (ram_cs),
    .state_q (state_q)
);

// File: tb/tb_rom_hop_pager.sv
module tb_rom_hop_pager;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_as_n = 1'b1;
    logic        bus_rd = 1'b1;
    logic        rom_cs, ram_cs;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    rom_hop_pager dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_as_n(bus_as_n), .bus_rd(bus_rd),
        .rom_cs(rom_cs), .ram_cs(ram_cs)
    );

    // {req tag, address, read, expected rom_cs, expected ram_cs}, walked in order
    localparam int NV = 20;
    localparam logic [26:0] VEC [NV] = '{
        {4'd6, 20'h10000, 3'b110},  // R6 exec read in boot: ROM, no change
        {4'd1, 20'hC0000, 3'b101},  // R1 boot window is RAM
        {4'd2, 20'h17FFF, 3'b110},  // R2 top of primary image
        {4'd2, 20'h18000, 3'b100},  // R2 just past primary
        {4'd7, 20'h0C000, 3'b000},  // R7 probe write
        {4'd7, 20'hC4000, 3'b101},  // R7 still boot
        {4'd8, 20'h10000, 3'b000},  // R8 write into ROM window
        {4'd3, 20'h0C000, 3'b100},  // R3 probe read
        {4'd4, 20'hC0000, 3'b110},  // R4 mirror read
        {4'd4, 20'hC7FFF, 3'b110},  // R4 mirror top
        {4'd2, 20'hC8000, 3'b100},  // R2 past mirror
        {4'd4, 20'hC1234, 3'b001},  // R4 write reaches RAM
        {4'd7, 20'h10000, 3'b000},  // R7 exec write
        {4'd7, 20'hC0010, 3'b110},  // R7 mirror still on
        {4'd9, 20'h0C000, 3'b100},  // R9 probe again, no effect
        {4'd5, 20'h10000, 3'b110},  // R5 exec read
        {4'd5, 20'hC0000, 3'b101},  // R5 window back to RAM
        {4'd9, 20'h0C000, 3'b100},  // R9 probe in final
        {4'd9, 20'hC0000, 3'b101},  // R9 still RAM
        {4'd2, 20'h12345, 3'b110}   // R2 primary in final
    };

    task automatic check(input int req, input string what, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL R%0d %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // start a strobe at a negedge, sample mid-cycle
    task automatic strobe_on(input logic [19:0] a, input logic rd);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_as_n = 1'b0;
        @(posedge clk); #5;
    endtask

    task automatic strobe_off(input int req);
        @(negedge clk);
        bus_as_n = 1'b1;
        @(posedge clk); #5;
        check(req, "idle rom_cs", rom_cs, 1'b0);   // R10
        check(req, "idle ram_cs", ram_cs, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; bus_as_n = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        @(posedge clk); #5;
        check(10, "reset idle rom", rom_cs, 1'b0);
        check(10, "reset idle ram", ram_cs, 1'b0);

        for (int i = 0; i < NV; i++) begin
            strobe_on(VEC[i][22:3], VEC[i][2]);
            check(int'(VEC[i][26:23]), $sformatf("vec%0d rom", i), rom_cs, VEC[i][1]);
            check(int'(VEC[i][26:23]), $sformatf("vec%0d ram", i), ram_cs, VEC[i][0]);
            strobe_off(10);
        end

        // R9: reset leaves final mapping, back to boot
        do_reset();
        strobe_on(20'hC0000, 1'b1);
        check(9, "after reset ram", ram_cs, 1'b1);
        check(1, "after reset rom", rom_cs, 1'b0);
        strobe_off(10);

        // R3: probe strobe then address moves into window, same strobe keeps boot map
        strobe_on(20'h0C000, 1'b1);
        @(negedge clk); bus_addr = 20'hC0000;
        @(posedge clk); #5;
        check(3, "same-strobe after probe ram", ram_cs, 1'b1);
        check(3, "same-strobe after probe rom", rom_cs, 1'b0);
        strobe_off(10);
        strobe_on(20'hC0000, 1'b1);
        check(3, "next strobe mirror rom", rom_cs, 1'b1);
        strobe_off(10);

        // R5: exec strobe then address moves into window, mirror still live
        strobe_on(20'h10000, 1'b1);
        @(negedge clk); bus_addr = 20'hC2000;
        @(posedge clk); #5;
        check(5, "same-strobe after exec rom", rom_cs, 1'b1);
        check(5, "same-strobe after exec ram", ram_cs, 1'b0);
        strobe_off(10);
        strobe_on(20'hC2000, 1'b1);
        check(5, "next strobe final ram", ram_cs, 1'b1);
        check(5, "next strobe final rom", rom_cs, 1'b0);
        strobe_off(10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule